// File: doc/BRIEF.md
# Interrupt translation command queue engine

This block drains a ring of commands that software keeps in system memory. Software gives it the ring base address and a write index. The engine then walks from its read index towards the write index. Each ring slot is 32 bytes and is read as 64-bit little-endian doublewords. The engine reads the first doubleword of a slot and decodes the opcode in its low byte. It reads more doublewords only when the command needs them. Device-map and collection-map commands are range-checked. Commands that pass the check go to a table-update unit over a request/acknowledge handshake. Every other opcode is retired without effect. After each retired command the read index moves forward one slot and wraps at the ring depth.

A bus error on a memory read, or an error answer from the table-update unit, freezes the engine. It sets a sticky stall flag and leaves the read index on the failing slot. Software resumes it in two steps: a write to the status register that clears the flag, then a new write-index write. Pointers outside the ring abort a pass before any slot is read.

Top module: `cq_engine`

## Requirements
- R1: No memory read is issued while the enable bit (control register, `reg_sel`=0, data bit 0) is clear. A pending write-index update is served once the enable bit is written to 1.
- R2: Doubleword k of slot i is read at address base + 32·i + 8·k. The base is taken from `reg_sel`=1 with its low 5 bits forced to zero.
- R3: Opcode 0x08 reads doublewords 0, 1 and 2. Opcode 0x09 reads doublewords 0 and 2. Every other opcode (sync 0x05, 0x03, 0x04, 0x0A–0x0D, 0x0F, unknown) reads doubleword 0 only, makes no table request, and advances the read index.
- R4: A device-map request carries the device ID from dw0[63:32], the size from dw1[4:0], the table address from dw2[51:8] and valid from dw2[63], with `tu_is_coll`=0. The request is held until `tu_ack`.
- R5: A collection-map request carries the collection ID from dw2[15:0] (on `tu_id`[15:0]), the target from dw2[31:16] and valid from dw2[63], with `tu_is_coll`=1.
- R6: A device map whose ID > MAX_DEVID or size > ID_BITS is dropped with no table request. So is a collection map whose ID > MAX_COLL or target > NUM_CPU. In both cases the read index still advances. Values equal to the limits are accepted.
- R7: After each retired command the read index becomes (index+1) mod DEPTH. `busy` falls when the read index equals the write index.
- R8: A memory error or table-update error sets `stalled`, keeps the read index on the failing slot and drops `busy`. While stalled, write-index writes start nothing. A status write (`reg_sel`=4) with data bit 0 = 0 clears `stalled` but does not restart the engine. Only a later write-index write restarts it.
- R9: If the read or write index is not below DEPTH, the pass ends with no memory read and no index change.
- R10: The write index sits in data bits [IW+4:5] of `reg_sel`=2, and bit 0 is a retry bit that is masked off. A write whose masked value equals the current read offset (read index·32) starts nothing.
- R11: A write-index write made while `busy` is taken into the running pass. The engine then stops at the newest write index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 control, 1 base, 2 write index, 3 read index, 4 status |
| reg_wdata | input | 64 | Register write data |
| rd_index | output | IW | Current read index |
| stalled | output | 1 | Sticky stall flag |
| busy | output | 1 | A pass is in progress |
| mem_req | output | 1 | Memory read request, held until acknowledge |
| mem_addr | output | AW | Byte address of the doubleword to read |
| mem_ack | input | 1 | Read response strobe |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Bus error, valid with `mem_ack` |
| tu_req | output | 1 | Table-update request, held until acknowledge |
| tu_is_coll | output | 1 | 1 collection map, 0 device map |
| tu_id | output | 32 | Device ID or zero-extended collection ID |
| tu_size | output | 5 | Device ID-size field |
| tu_addr | output | 44 | Translation table address |
| tu_target | output | 16 | Target processor number |
| tu_valid | output | 1 | Map (1) or unmap (0) |
| tu_ack | input | 1 | Table-update completion strobe |
| tu_err | input | 1 | Table-update error, valid with `tu_ack` |

## Verification
The ring is loaded with several patterns: a mix of valid device and collection maps, runs of opcodes that have no effect, maps sitting exactly on and just past each limit, and a span that wraps past the last slot. The request stream and the read count per pass separate decode faults from dispatch faults, and the final index shows whether wrap-around is correct. Stall tests place an error on a later doubleword of a map command and on a table update. They then check that the engine stays idle until both the clear and the new write arrive. Retry-bit writes, out-of-range indices and a write landing mid-pass cover the triggering rules.

// File: rtl/cq_pkg.sv
// Shared constants and types for the command queue engine.
// Assumes register selects and opcodes are fixed by software convention.
package cq_pkg;
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_BASE = 3'd1;
    localparam logic [2:0] SEL_WIDX = 3'd2;
    localparam logic [2:0] SEL_RIDX = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;

    localparam logic [7:0] OP_DEVMAP  = 8'h08;
    localparam logic [7:0] OP_COLLMAP = 8'h09;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_RD0, ST_RD1, ST_RD2, ST_DECIDE, ST_TU, ST_RETIRE
    } eng_state_t;
endpackage

// File: rtl/cq_param_check.sv
// Range check for map commands.
// Assumes its inputs are stable while the sequencer is in its decide state.
module cq_param_check #(
    parameter logic [31:0] MAX_DEVID = 32'h0000_FFFF,
    parameter logic [4:0]  ID_BITS   = 5'd16,
    parameter logic [15:0] MAX_COLL  = 16'd63,
    parameter logic [15:0] NUM_CPU   = 16'd4
) (
    input  logic        is_coll,
    input  logic [31:0] dev_id,
    input  logic [4:0]  size,
    input  logic [15:0] coll_id,
    input  logic [15:0] target,
    output logic        ok
);
    // Accept a command whose fields are all within their limits.
    always_comb begin
        if (is_coll) ok = (coll_id <= MAX_COLL) && (target <= NUM_CPU);
        else         ok = (dev_id <= MAX_DEVID) && (size <= ID_BITS);
    end
endmodule

// File: rtl/cq_regs.sv
// Register block: enable, base, write/read indices, sticky stall and the
// pending-pass flag. Assumes the sequencer raises rd_adv and stall_set
// only while it is busy, and never both in the same cycle.
module cq_regs
    import cq_pkg::*;
#(
    parameter int AW    = 48,
    parameter int IW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [63:0]   reg_wdata,
    input  logic          eng_idle,
    input  logic          pass_start,
    input  logic          rd_adv,
    input  logic          stall_set,
    output logic          en,
    output logic [AW-1:0] qbase,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] rd_idx,
    output logic          stalled,
    output logic          pending
);
    localparam int OFSW = IW + 5;
    localparam logic [IW:0] DEPTH_W = (IW+1)'(DEPTH);

    logic [OFSW-1:0] widx_new;
    logic ctrl_we, base_we, widx_we, ridx_we, stat_clr, trig;
    logic [IW-1:0] rd_next;
    logic unused_hi;

    assign unused_hi = ^reg_wdata[63:AW-1];

    // Decode writes; the retry bit (bit 0) is masked before compare/store.
    always_comb begin
        ctrl_we  = reg_we && (reg_sel == SEL_CTRL);
        base_we  = reg_we && (reg_sel == SEL_BASE);
        widx_we  = reg_we && (reg_sel == SEL_WIDX);
        ridx_we  = reg_we && (reg_sel == SEL_RIDX);
        stat_clr = reg_we && (reg_sel == SEL_STAT) && !reg_wdata[0];
        widx_new = reg_wdata[OFSW-1:0] & ~OFSW'(1);
        trig     = widx_we && (widx_new != {rd_idx, 5'b0}) && !stalled;
        rd_next  = (rd_idx == IW'(DEPTH-1)) ? '0 : rd_idx + 1'b1;
    end

    // Register state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            qbase   <= '0;
            wr_idx  <= '0;
            rd_idx  <= '0;
            stalled <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (ctrl_we) en <= reg_wdata[0];
            if (base_we) qbase <= {reg_wdata[AW-1:5], 5'b0};
            if (widx_we) wr_idx <= widx_new[OFSW-1:5];
            if (rd_adv)
                rd_idx <= rd_next;
            else if (ridx_we && eng_idle)
                rd_idx <= reg_wdata[OFSW-1:5];
            if (stall_set)     stalled <= 1'b1;
            else if (stat_clr) stalled <= 1'b0;
            if (stall_set || stat_clr)
                pending <= 1'b0;
            else if (trig || (ctrl_we && reg_wdata[0] && !stalled))
                pending <= 1'b1;
            else if (pass_start)
                pending <= 1'b0;
        end
    end

    AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stalled && !stat_clr |=> stalled); // R8
    AST_ERR_FREEZES_RD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_set |=> $stable(rd_idx)); // R8
    AST_ADV_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> ({1'b0, rd_idx} < DEPTH_W)); // R7
endmodule

// File: rtl/cq_seq.sv
// Command sequencer: checks pointers, fetches doublewords of the slot at
// the read index, decodes the opcode, dispatches map commands and retires.
// Assumes mem_ack and tu_ack are single-cycle strobes answering a held request.
module cq_seq
    import cq_pkg::*;
#(
    parameter int AW    = 48,
    parameter int IW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] qbase,
    input  logic [IW-1:0] wr_idx,
    input  logic [IW-1:0] rd_idx,
    input  logic          stalled,
    input  logic          pending,
    input  logic          mem_ack,
    input  logic [63:0]   mem_rdata,
    input  logic          mem_err,
    input  logic          tu_ack,
    input  logic          tu_err,
    input  logic          params_ok,
    output logic          busy,
    output logic          pass_start,
    output logic          rd_adv,
    output logic          stall_set,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          tu_req,
    output logic          is_coll,
    output logic [31:0]   dev_id,
    output logic [4:0]    size,
    output logic [63:0]   dw2
);
    localparam logic [IW:0] DEPTH_W = (IW+1)'(DEPTH);

    eng_state_t state;
    logic [1:0] dw_sel;
    logic bad_ptr;

    // Control outputs and fetch address derived from the state.
    always_comb begin
        busy       = (state != ST_IDLE);
        pass_start = (state == ST_IDLE) && pending && en && !stalled;
        mem_req    = (state == ST_RD0) || (state == ST_RD1) || (state == ST_RD2);
        tu_req     = (state == ST_TU);
        rd_adv     = (state == ST_RETIRE);
        dw_sel     = (state == ST_RD1) ? 2'd1 : (state == ST_RD2) ? 2'd2 : 2'd0;
        mem_addr   = qbase + AW'({rd_idx, dw_sel, 3'b000});
        bad_ptr    = ({1'b0, rd_idx} >= DEPTH_W) || ({1'b0, wr_idx} >= DEPTH_W);
        stall_set  = (mem_req && mem_ack && mem_err) ||
                     ((state == ST_TU) && tu_ack && tu_err);
    end

    // Sequencer state and captured command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            is_coll <= 1'b0;
            dev_id  <= '0;
            size    <= '0;
            dw2     <= '0;
        end else begin
            case (state)
                ST_IDLE:   if (pass_start) state <= ST_CHECK;
                ST_CHECK:  begin
                    if (!en || bad_ptr || (rd_idx == wr_idx)) state <= ST_IDLE;
                    else                                      state <= ST_RD0;
                end
                ST_RD0:    if (mem_ack) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        dev_id <= mem_rdata[63:32];
                        if (mem_rdata[7:0] == OP_DEVMAP) begin
                            is_coll <= 1'b0;
                            state   <= ST_RD1;
                        end else if (mem_rdata[7:0] == OP_COLLMAP) begin
                            is_coll <= 1'b1;
                            state   <= ST_RD2;
                        end else begin
                            state <= ST_RETIRE;
                        end
                    end
                end
                ST_RD1:    if (mem_ack) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        size  <= mem_rdata[4:0];
                        state <= ST_RD2;
                    end
                end
                ST_RD2:    if (mem_ack) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        dw2   <= mem_rdata;
                        state <= ST_DECIDE;
                    end
                end
                ST_DECIDE: state <= params_ok ? ST_TU : ST_RETIRE;
                ST_TU:     if (tu_ack) state <= tu_err ? ST_IDLE : ST_RETIRE;
                ST_RETIRE: state <= ST_CHECK;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R2
    AST_TU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tu_req && !tu_ack |=> tu_req && $stable(dw2) && $stable(dev_id)); // R4
    AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> !busy); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !en |=> !mem_req); // R1
endmodule

// File: rtl/cq_engine.sv
// Top of the command queue engine: register block, sequencer and the map
// parameter check. Assumes one outstanding memory read and one outstanding
// table update at a time.
module cq_engine #(
    parameter int          AW        = 48,
    parameter int          IW        = 8,
    parameter int          DEPTH     = 16,
    parameter logic [31:0] MAX_DEVID = 32'h0000_FFFF,
    parameter logic [4:0]  ID_BITS   = 5'd16,
    parameter logic [15:0] MAX_COLL  = 16'd63,
    parameter logic [15:0] NUM_CPU   = 16'd4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [63:0]   reg_wdata,
    output logic [IW-1:0] rd_index,
    output logic          stalled,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [63:0]   mem_rdata,
    input  logic          mem_err,
    output logic          tu_req,
    output logic          tu_is_coll,
    output logic [31:0]   tu_id,
    output logic [4:0]    tu_size,
    output logic [43:0]   tu_addr,
    output logic [15:0]   tu_target,
    output logic          tu_valid,
    input  logic          tu_ack,
    input  logic          tu_err
);
    logic          en, pending, pass_start, rd_adv, stall_set, params_ok;
    logic [AW-1:0] qbase;
    logic [IW-1:0] wr_idx;
    logic [31:0]   dev_id;
    logic [4:0]    size;
    logic [63:0]   dw2;
    logic          unused_dw2;

    assign unused_dw2 = ^{dw2[62:52], dw2[7:0]};

    cq_regs #(.AW(AW), .IW(IW), .DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .eng_idle(!busy), .pass_start(pass_start),
        .rd_adv(rd_adv), .stall_set(stall_set), .en(en), .qbase(qbase),
        .wr_idx(wr_idx), .rd_idx(rd_index), .stalled(stalled), .pending(pending)
    );

    cq_seq #(.AW(AW), .IW(IW), .DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .qbase(qbase), .wr_idx(wr_idx),
        .rd_idx(rd_index), .stalled(stalled), .pending(pending),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .tu_ack(tu_ack), .tu_err(tu_err), .params_ok(params_ok),
        .busy(busy), .pass_start(pass_start), .rd_adv(rd_adv),
        .stall_set(stall_set), .mem_req(mem_req), .mem_addr(mem_addr),
        .tu_req(tu_req), .is_coll(tu_is_coll), .dev_id(dev_id),
        .size(size), .dw2(dw2)
    );

    cq_param_check #(.MAX_DEVID(MAX_DEVID), .ID_BITS(ID_BITS),
                     .MAX_COLL(MAX_COLL), .NUM_CPU(NUM_CPU)) u_check (
        .is_coll(tu_is_coll), .dev_id(dev_id), .size(size),
        .coll_id(dw2[15:0]), .target(dw2[31:16]), .ok(params_ok)
    );

    // Table-update fields presented from the captured doublewords.
    always_comb begin
        tu_id     = tu_is_coll ? {16'b0, dw2[15:0]} : dev_id;
        tu_size   = size;
        tu_addr   = dw2[51:8];
        tu_target = dw2[31:16];
        tu_valid  = dw2[63];
    end
endmodule

// File: tb/tb_cq_engine.sv
// Bench: memory and table-update responders, a command-level reference
// model of the ring walk, and per-clock comparison of table requests.
module tb_cq_engine;
    localparam int D = 8;
    localparam logic [47:0] QB = 48'h1000;
    localparam logic [31:0] LIM_DEV  = 32'h0000_FFFF;
    localparam logic [4:0]  LIM_SIZE = 5'd16;
    localparam logic [15:0] LIM_COLL = 16'd63;
    localparam logic [15:0] LIM_CPU  = 16'd4;

    logic clk = 0, rst_n = 0;
    logic reg_we = 0; logic [2:0] reg_sel = 0; logic [63:0] reg_wdata = 0;
    logic [7:0] rd_index; logic stalled, busy, mem_req; logic [47:0] mem_addr;
    logic mem_ack = 0, mem_err = 0; logic [63:0] mem_rdata = 0;
    logic tu_req, tu_is_coll, tu_valid; logic [31:0] tu_id; logic [4:0] tu_size;
    logic [43:0] tu_addr; logic [15:0] tu_target;
    logic tu_ack = 0, tu_err = 0;

    cq_engine #(.AW(48), .IW(8), .DEPTH(D)) dut (.*);

    always #10 clk = ~clk;

    logic [63:0] mem [0:31];
    logic [98:0] exp_q[$];
    int total = 0, bad = 0, fetch_cnt = 0, err_word = -1, cycles = 0;
    bit tu_fail = 0;
    int exp_rd, exp_fetch; bit exp_stall;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [98:0] pk(bit c, logic [31:0] id, logic [4:0] sz,
                                       logic [43:0] ad, logic [15:0] tg, bit v);
        return c ? {1'b1, id, 5'b0, 44'b0, tg, v} : {1'b0, id, sz, ad, 16'b0, v};
    endfunction

    // Memory responder: one-cycle ack after each held request.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 0; mem_err <= 0;
        end else if (mem_req) begin
            int w;
            w = int'((mem_addr - QB) >> 3);
            fetch_cnt++;
            if (w < 0 || w > 31) begin
                chk(0, "R2", "fetch address", mem_addr, QB); w = 0;
            end
            mem_rdata <= mem[w];
            mem_err <= (w == err_word);
            if (w == err_word) err_word = -1;
            mem_ack <= 1;
        end
    end

    // Table-update responder compares every request with the model queue.
    always @(negedge clk) begin
        if (tu_ack) begin
            tu_ack <= 0; tu_err <= 0;
        end else if (tu_req) begin
            logic [98:0] act, exp;
            act = pk(tu_is_coll, tu_id, tu_size, tu_addr, tu_target, tu_valid);
            if (exp_q.size() == 0) chk(0, "R6", "unexpected table request", act, 0);
            else begin
                exp = exp_q.pop_front();
                chk(act == exp, tu_is_coll ? "R5" : "R4", "table request fields", act, exp);
            end
            tu_err <= tu_fail; tu_fail = 0; tu_ack <= 1;
        end
    end

    // Per-clock invariant: never busy while stalled.
    always @(negedge clk) if (rst_n && stalled && busy) chk(0, "R8", "busy while stalled", 1, 0);

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr_reg(logic [2:0] s, logic [63:0] d);
        @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    task automatic put(int i, logic [63:0] a, logic [63:0] b, logic [63:0] c);
        mem[i*4] = a; mem[i*4+1] = b; mem[i*4+2] = c; mem[i*4+3] = 0;
    endtask

    // Reference model of one pass over the ring.
    task automatic predict(int from, int to, int errw, bit tf);
        int r; r = from; exp_fetch = 0; exp_stall = 0;
        if (from >= D || to >= D) begin exp_rd = from; return; end
        while (r != to) begin
            logic [63:0] d0, d1, d2;
            d0 = mem[r*4]; d1 = mem[r*4+1]; d2 = mem[r*4+2];
            exp_fetch++;
            if (errw == r*4) begin exp_stall = 1; break; end
            if (d0[7:0] == 8'h08) begin
                exp_fetch++;
                if (errw == r*4+1) begin exp_stall = 1; break; end
                exp_fetch++;
                if (errw == r*4+2) begin exp_stall = 1; break; end
                if (d0[63:32] <= LIM_DEV && d1[4:0] <= LIM_SIZE) begin
                    exp_q.push_back(pk(0, d0[63:32], d1[4:0], d2[51:8], 0, d2[63]));
                    if (tf) begin exp_stall = 1; break; end
                end
            end else if (d0[7:0] == 8'h09) begin
                exp_fetch++;
                if (errw == r*4+2) begin exp_stall = 1; break; end
                if (d2[15:0] <= LIM_COLL && d2[31:16] <= LIM_CPU) begin
                    exp_q.push_back(pk(1, {16'b0, d2[15:0]}, 0, 0, d2[31:16], d2[63]));
                    if (tf) begin exp_stall = 1; break; end
                end
            end
            r = (r + 1) % D;
        end
        exp_rd = r;
    endtask

    task automatic end_checks(string tag);
        chk(rd_index == exp_rd[7:0], tag, "read index", rd_index, exp_rd);
        chk(stalled == exp_stall, tag, "stall flag", stalled, exp_stall);
        chk(fetch_cnt == exp_fetch, tag, "doubleword reads", fetch_cnt, exp_fetch);
        chk(exp_q.size() == 0, tag, "missing table requests", exp_q.size(), 0);
        chk(!busy, tag, "busy after pass", busy, 0);
    endtask

    task automatic run(int from, int to, int errw, bit tf, string tag);
        fetch_cnt = 0; err_word = errw; tu_fail = tf;
        predict(from, to, errw, tf);
        wr_reg(3'd2, 64'(to) << 5);
        wait_idle();
        end_checks(tag);
    endtask

    task automatic quiet(string tag, string what);
        bit seen; seen = 0;
        repeat (12) begin @(negedge clk); if (busy || mem_req) seen = 1; end
        chk(!seen && fetch_cnt == 0, tag, what, fetch_cnt, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_index == 0 && !stalled && !busy && !mem_req, "R7", "reset state",
            {rd_index, stalled, busy, mem_req}, 0);

        wr_reg(3'd1, {16'b0, QB} | 64'h1F);   // low bits must be ignored (R2)

        // R1: disabled engine ignores the write index until enabled
        put(0, 64'h0000_1234_0000_0008, 64'd7, {1'b1, 11'b0, 44'hABC_DEF0_1234, 8'h0});
        put(1, 64'h09, 64'd0, {1'b1, 31'b0, 16'd3, 16'd42});
        fetch_cnt = 0;
        wr_reg(3'd2, 64'd2 << 5);
        quiet("R1", "reads while disabled");
        predict(0, 2, -1, 0);
        wr_reg(3'd0, 64'd1);
        wait_idle();
        end_checks("R1");

        // R3: opcodes with no effect read only doubleword 0
        put(2, 64'h05, 0, 0); put(3, 64'h03, 0, 0);
        put(4, 64'h0F, 0, 0); put(5, 64'hAA, 64'h1, {1'b1, 63'h0});
        run(2, 6, -1, 0, "R3");

        // R6 and R7: drops, limit values, wrap past the last slot
        put(6, 64'h0001_0000_0000_0008, 64'd1, {1'b1, 63'h100});
        put(7, 64'h0000_0001_0000_0008, 64'd17, {1'b1, 63'h100});
        put(0, 64'h09, 0, {1'b1, 31'b0, 16'd1, 16'd64});
        put(1, 64'h09, 0, {1'b1, 31'b0, 16'd5, 16'd2});
        put(2, 64'h09, 0, {1'b0, 31'b0, 16'd4, 16'd63});
        put(3, 64'h0000_FFFF_0000_0008, 64'd16, {12'h800, 44'h123_4567_89AB, 8'h0});
        run(6, 4, -1, 0, "R6");
        chk(rd_index == 4, "R7", "wrapped read index", rd_index, 4);

        // R10: retry bit alone does not start a pass
        fetch_cnt = 0;
        wr_reg(3'd2, (64'd4 << 5) | 64'd1);
        quiet("R10", "start on retry bit");
        chk(rd_index == 4, "R10", "read index unchanged", rd_index, 4);

        // R9: out-of-ring write index, then out-of-ring read index
        fetch_cnt = 0;
        wr_reg(3'd2, 64'd9 << 5);
        repeat (10) @(negedge clk);
        chk(fetch_cnt == 0 && rd_index == 4, "R9", "abort on write index", fetch_cnt, 0);
        wr_reg(3'd3, 64'd10 << 5);
        wr_reg(3'd2, 64'd5 << 5);
        repeat (10) @(negedge clk);
        chk(fetch_cnt == 0 && rd_index == 10, "R9", "abort on read index", rd_index, 10);
        wr_reg(3'd3, 64'd4 << 5);
        wr_reg(3'd2, 64'd4 << 5);

        // R8: memory error on dw2 of a device map
        put(4, 64'h05, 0, 0);
        put(5, 64'h0000_0022_0000_0008, 64'd3, {1'b1, 11'b0, 44'h55, 8'h0});
        put(6, 64'h05, 0, 0);
        run(4, 7, 5*4+2, 0, "R8");
        fetch_cnt = 0;
        wr_reg(3'd2, 64'd6 << 5);
        quiet("R8", "restart while stalled");
        wr_reg(3'd4, 64'd0);
        chk(!stalled, "R8", "stall cleared", stalled, 0);
        quiet("R8", "restart on clear alone");
        run(5, 7, -1, 0, "R8");

        // R8: table-update error
        put(7, 64'h09, 0, {1'b1, 31'b0, 16'd2, 16'd9});
        run(7, 0, -1, 1, "R8");
        wr_reg(3'd4, 64'd0);
        run(7, 0, -1, 0, "R8");

        // R11: write index moved while busy
        put(0, 64'h05, 0, 0); put(1, 64'h0C, 0, 0);
        put(2, 64'h0000_0100_0000_0008, 64'd4, {1'b0, 11'b0, 44'h77, 8'h0});
        put(3, 64'h09, 0, {1'b1, 31'b0, 16'd0, 16'd0});
        fetch_cnt = 0;
        predict(0, 4, -1, 0);
        wr_reg(3'd2, 64'd2 << 5);
        @(negedge clk);
        chk(busy, "R11", "busy during pass", busy, 1);
        reg_we = 1; reg_sel = 3'd2; reg_wdata = 64'd4 << 5;
        @(negedge clk); reg_we = 0;
        wait_idle();
        end_checks("R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule